// File: doc/BRIEF.md
# Output-Stationary Transposed-Convolution Tile Unit

This block computes one square output tile of a transposed-convolution layer. It does not scatter each input pixel into overlapping output windows. It walks the output tile directly. For every kernel row and column it starts at a cached phase offset and steps by the stride, so every input coordinate it derives falls exactly on an input pixel. No zero insertion is needed, partial sums never overlap, and no modulo logic runs per pixel. The offsets and the matching first input coordinates are computed once per layer, one entry per kernel index, during a short setup phase after `start_i`.

Operation is as follows. A start pulse latches the layer shape: stride, padding, kernel size, channel count, output tile side, input tile side and the input-tile origin. The same pulse fills the whole accumulator tile with the bias. For each input channel the unit then accepts, on one valid/ready stream, the cached input tile followed by that channel's K×K weights. It accumulates one product per cycle into the local tile. When the last channel is finished, the tile streams out once over a valid/ready port and `done_o` is raised.

Output coordinates are local to the tile, and the tile's first output row and column are assumed to be stride-aligned in the layer. Input coordinates are given relative to the origin of the cached input tile. The stride and the kernel size must be at least 1.

Top module: `deconv_cu`

## Requirements
- R1: The edge that samples `start_i` in the idle or done state latches all layer inputs and sets every accumulator entry to `bias_i`. A tile whose weights are all zero therefore streams `bias_i` in every pixel.
- R2: Output pixel (oh, ow) equals `bias_i` plus the sum of products w[c][kh][kw]·x[c][li][lj] over all channels c, kernel indices kh, kw < K, and local input indices li, lj < `in_tile_i` that satisfy both oh = (`in_org_h_i`+li)·S + kh − P and ow = (`in_org_w_i`+lj)·S + kw − P.
- R3: Each channel is loaded as `in_tile_i`² input words in row-major order, followed by K² weight words in row-major order (kernel row outer). `in_ready_o` is high only while a channel is being loaded.
- R4: A kernel position whose weight is zero costs exactly one cycle and accumulates nothing.
- R5: After the last weight word of a channel is accepted, `in_ready_o` (or `out_valid_o` after the last channel) rises after exactly K² + nz·⌈T/S⌉² rising edges, where nz is the channel's count of nonzero weights.
- R6: Contributions whose input coordinate falls outside [0, `in_tile_i`) of the cached tile, and contributions whose output coordinate is not below T, are dropped.
- R7: The tile streams out in row-major order, one pixel per accepted beat. While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value.
- R8: `done_o` rises on the edge after the last output beat is accepted and stays high until the next start. While it is high, `out_valid_o` and `in_ready_o` are low. After reset, all three outputs are low.
- R9: A product is the full 64-bit signed product w·x, arithmetically shifted right by FRAC_W and truncated to 32 bits. Accumulation wraps modulo 2³².
- R10: After the edge that samples `start_i`, `in_ready_o` rises after exactly K further rising edges, one per cached offset entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a tile; latches the layer inputs |
| stride_i | input | 3 | Stride S (1..MAX_S) |
| pad_i | input | 3 | Padding P (0..MAX_K-1) |
| ksize_i | input | 3 | Kernel side K (1..MAX_K) |
| n_ch_i | input | 3 | Number of input channels (1..MAX_IC) |
| tile_i | input | 4 | Output tile side T (1..MAX_T) |
| in_tile_i | input | 4 | Cached input tile side (1..MAX_IT) |
| in_org_h_i | input | 8 | Signed input row of the cached tile's first row |
| in_org_w_i | input | 8 | Signed input column of the cached tile's first column |
| bias_i | input | 32 | Bias loaded into every output entry |
| in_valid_i | input | 1 | Load word valid |
| in_ready_o | output | 1 | Load word accepted |
| in_data_i | input | 32 | Input pixel or weight word |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream accepts output pixel |
| out_data_o | output | 32 | Output pixel |
| done_o | output | 1 | Tile fully delivered |

## Verification
The bench builds the unit with its default parameters: a kernel side of up to 4, a stride of up to 4, 8×8 output and input tiles, 4 channels and 8 fraction bits. It sweeps strides 1 to 3, every kernel side from 1 to 4 and every legal padding. Ragged tile sides and negative and positive input-tile origins are mixed in, so the offset table covers every phase of every stride. Input and output skipping at the tile edges is also reached. Randomly placed zero weights and a fully zero tile drive the zero-skip timing, and a directed large-value case reaches 32-bit wrap in the fixed-point product.

// File: rtl/deconv_cu_pkg.sv
package deconv_cu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_LOAD, ST_KPOS, ST_SWEEP, ST_OUT, ST_DONE
  } cu_state_e;
endpackage

// File: rtl/deconv_offset_table.sv
// Per-kernel-index phase offset and first input coordinate, filled once per layer.
module deconv_offset_table #(
  parameter int MAX_K = 4,
  parameter int MAX_S = 4,
  parameter int IXW   = 10,
  localparam int SW   = $clog2(MAX_S + 1),
  localparam int KW   = $clog2(MAX_K + 1),
  localparam int KIW  = $clog2(MAX_K)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [KIW-1:0]        wr_idx_i,
  input  logic [SW-1:0]         stride_i,
  input  logic [KW-1:0]         pad_i,
  input  logic [KIW-1:0]        rd_a_i,
  input  logic [KIW-1:0]        rd_b_i,
  output logic [SW-1:0]         off_a_o,
  output logic [SW-1:0]         off_b_o,
  output logic signed [IXW-1:0] base_a_o,
  output logic signed [IXW-1:0] base_b_o
);
  logic [SW-1:0]         off_q  [MAX_K];
  logic signed [IXW-1:0] base_q [MAX_K];

  logic signed [IXW-1:0] s_ext, num, rem, off_v, quo;

  always_comb begin
    s_ext = $signed({{(IXW-SW){1'b0}}, stride_i});
    if (s_ext == '0) s_ext = IXW'(1);
    num = $signed({{(IXW-KW){1'b0}}, pad_i}) - $signed({{(IXW-KIW){1'b0}}, wr_idx_i});
    rem = num % s_ext;
    if (rem < 0) rem = rem + s_ext;
    off_v = (rem == '0) ? '0 : s_ext - rem;
    quo = (num + off_v) / s_ext;  // exact by construction of off_v
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_K; i++) begin
        off_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else if (wr_i) begin
      off_q[wr_idx_i]  <= SW'(off_v);
      base_q[wr_idx_i] <= quo;
    end
  end

  assign off_a_o  = off_q[rd_a_i];
  assign off_b_o  = off_q[rd_b_i];
  assign base_a_o = base_q[rd_a_i];
  assign base_b_o = base_q[rd_b_i];
endmodule

// File: rtl/deconv_mac.sv
module deconv_mac #(
  parameter int DW     = 32,
  parameter int FRAC_W = 8
) (
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] p_o
);
  logic signed [2*DW-1:0] prod;
  assign prod = $signed({{DW{w_i[DW-1]}}, w_i}) * $signed({{DW{x_i[DW-1]}}, x_i});
  assign p_o  = DW'(prod >>> FRAC_W);
endmodule

// File: rtl/deconv_acc_tile.sv
module deconv_acc_tile #(
  parameter int DW = 32,
  parameter int N  = 64,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [DW-1:0] bias_i,
  input  logic          acc_en_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] addend_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] y_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) y_q[i] <= '0;
    end else if (init_i) begin
      for (int i = 0; i < N; i++) y_q[i] <= bias_i;
    end else if (acc_en_i) begin
      y_q[acc_addr_i] <= y_q[acc_addr_i] + addend_i;
    end
  end

  assign rd_data_o = y_q[rd_addr_i];
endmodule

// File: rtl/deconv_cu.sv
module deconv_cu
  import deconv_cu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FRAC_W = 8,
  parameter int MAX_K  = 4,
  parameter int MAX_S  = 4,
  parameter int MAX_T  = 8,
  parameter int MAX_IT = 8,
  parameter int MAX_IC = 4,
  parameter int ORW    = 8,
  localparam int SW    = $clog2(MAX_S + 1),
  localparam int KW    = $clog2(MAX_K + 1),
  localparam int TW    = $clog2(MAX_T + 1),
  localparam int ITW   = $clog2(MAX_IT + 1),
  localparam int ICW   = $clog2(MAX_IC + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SW-1:0]         stride_i,
  input  logic [KW-1:0]         pad_i,
  input  logic [KW-1:0]         ksize_i,
  input  logic [ICW-1:0]        n_ch_i,
  input  logic [TW-1:0]         tile_i,
  input  logic [ITW-1:0]        in_tile_i,
  input  logic signed [ORW-1:0] in_org_h_i,
  input  logic signed [ORW-1:0] in_org_w_i,
  input  logic [DW-1:0]         bias_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [DW-1:0]         in_data_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [DW-1:0]         out_data_o,
  output logic                  done_o
);
  localparam int KIW  = $clog2(MAX_K);
  localparam int TIW  = $clog2(MAX_T);
  localparam int ITIW = $clog2(MAX_IT);
  localparam int BW   = $clog2(MAX_T + MAX_S + 1);
  localparam int IXW  = ORW + 2;
  localparam int XN   = MAX_IT * MAX_IT;
  localparam int XAW  = $clog2(XN);
  localparam int WN   = MAX_K * MAX_K;
  localparam int WAW  = $clog2(WN);
  localparam int YN   = MAX_T * MAX_T;
  localparam int YAW  = $clog2(YN);

  cu_state_e st_q, adv_st;

  logic [SW-1:0]         s_q;
  logic [KW-1:0]         p_q, k_q;
  logic [ICW-1:0]        nch_q, ic_q, adv_ic;
  logic [TW-1:0]         t_q;
  logic [ITW-1:0]        it_q;
  logic signed [ORW-1:0] orgh_q, orgw_q;

  logic [KIW-1:0]        prep_k_q, kh_q, kw_q, adv_kh, adv_kw;
  logic [ITIW-1:0]       ld_r_q, ld_c_q;
  logic                  ld_w_q;
  logic [BW-1:0]         bh_q, bw_q;
  logic signed [IXW-1:0] ih_q, iw_q, iw0_q;
  logic [TIW-1:0]        out_r_q, out_c_q;

  logic [DW-1:0] x_mem [XN];
  logic [DW-1:0] w_mem [WN];

  logic                  start_go, ld_fire;
  logic [SW-1:0]         fh, fw;
  logic signed [IXW-1:0] i0h, i0w, orgh_ext, orgw_ext, it_ext;
  logic [BW-1:0]         oh, ow, bh_nxt, bw_nxt, t_ext;
  logic                  in_ok, out_ok, acc_en;
  logic [DW-1:0]         w_cur, x_rd, prod;
  logic                  kw_last, kh_last, ic_last;

  assign start_go = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign ld_fire  = (st_q == ST_LOAD) && in_valid_i;

  deconv_offset_table #(.MAX_K(MAX_K), .MAX_S(MAX_S), .IXW(IXW)) u_tab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (st_q == ST_PREP),
    .wr_idx_i (prep_k_q),
    .stride_i (s_q),
    .pad_i    (p_q),
    .rd_a_i   (kh_q),
    .rd_b_i   (kw_q),
    .off_a_o  (fh),
    .off_b_o  (fw),
    .base_a_o (i0h),
    .base_b_o (i0w)
  );

  // sweep addressing
  assign orgh_ext = $signed({{(IXW-ORW){orgh_q[ORW-1]}}, orgh_q});
  assign orgw_ext = $signed({{(IXW-ORW){orgw_q[ORW-1]}}, orgw_q});
  assign it_ext   = $signed({{(IXW-ITW){1'b0}}, it_q});
  assign t_ext    = BW'(t_q);
  assign oh       = bh_q + BW'(fh);
  assign ow       = bw_q + BW'(fw);
  assign bh_nxt   = bh_q + BW'(s_q);
  assign bw_nxt   = bw_q + BW'(s_q);
  assign in_ok    = (ih_q >= 0) && (ih_q < it_ext) && (iw_q >= 0) && (iw_q < it_ext);
  assign out_ok   = (oh < t_ext) && (ow < t_ext);
  assign acc_en   = (st_q == ST_SWEEP) && in_ok && out_ok;

  assign w_cur = w_mem[WAW'(int'(kh_q) * MAX_K + int'(kw_q))];
  assign x_rd  = in_ok ? x_mem[XAW'(int'(ih_q[ITIW-1:0]) * MAX_IT + int'(iw_q[ITIW-1:0]))] : '0;

  deconv_mac #(.DW(DW), .FRAC_W(FRAC_W)) u_mac (
    .w_i (w_cur),
    .x_i (x_rd),
    .p_o (prod)
  );

  deconv_acc_tile #(.DW(DW), .N(YN)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (start_go),
    .bias_i     (bias_i),
    .acc_en_i   (acc_en),
    .acc_addr_i (YAW'(int'(oh) * MAX_T + int'(ow))),
    .addend_i   (prod),
    .rd_addr_i  (YAW'(int'(out_r_q) * MAX_T + int'(out_c_q))),
    .rd_data_o  (out_data_o)
  );

  // kernel-position advance: kw inner, kh, then channel
  assign kw_last = (KW'(kw_q) + KW'(1)) == k_q;
  assign kh_last = (KW'(kh_q) + KW'(1)) == k_q;
  assign ic_last = (ic_q + ICW'(1)) == nch_q;

  always_comb begin
    adv_kw = kw_q;
    adv_kh = kh_q;
    adv_ic = ic_q;
    adv_st = ST_KPOS;
    if (!kw_last) begin
      adv_kw = kw_q + KIW'(1);
    end else begin
      adv_kw = '0;
      if (!kh_last) begin
        adv_kh = kh_q + KIW'(1);
      end else begin
        adv_kh = '0;
        if (ic_last) adv_st = ST_OUT;
        else begin
          adv_ic = ic_q + ICW'(1);
          adv_st = ST_LOAD;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_fire && !ld_w_q)
      x_mem[XAW'(int'(ld_r_q) * MAX_IT + int'(ld_c_q))] <= in_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_fire && ld_w_q)
      w_mem[WAW'(int'(ld_r_q) * MAX_K + int'(ld_c_q))] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      s_q      <= '0;
      p_q      <= '0;
      k_q      <= '0;
      nch_q    <= '0;
      t_q      <= '0;
      it_q     <= '0;
      orgh_q   <= '0;
      orgw_q   <= '0;
      prep_k_q <= '0;
      ld_r_q   <= '0;
      ld_c_q   <= '0;
      ld_w_q   <= 1'b0;
      ic_q     <= '0;
      kh_q     <= '0;
      kw_q     <= '0;
      bh_q     <= '0;
      bw_q     <= '0;
      ih_q     <= '0;
      iw_q     <= '0;
      iw0_q    <= '0;
      out_r_q  <= '0;
      out_c_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            s_q      <= stride_i;
            p_q      <= pad_i;
            k_q      <= ksize_i;
            nch_q    <= n_ch_i;
            t_q      <= tile_i;
            it_q     <= in_tile_i;
            orgh_q   <= in_org_h_i;
            orgw_q   <= in_org_w_i;
            prep_k_q <= '0;
            out_r_q  <= '0;
            out_c_q  <= '0;
            st_q     <= ST_PREP;
          end
        end
        ST_PREP: begin
          if ((KW'(prep_k_q) + KW'(1)) == k_q) begin
            ld_r_q <= '0;
            ld_c_q <= '0;
            ld_w_q <= 1'b0;
            ic_q   <= '0;
            st_q   <= ST_LOAD;
          end else begin
            prep_k_q <= prep_k_q + KIW'(1);
          end
        end
        ST_LOAD: begin
          if (in_valid_i) begin
            if (!ld_w_q) begin
              if ((ITW'(ld_c_q) + ITW'(1)) == it_q) begin
                ld_c_q <= '0;
                if ((ITW'(ld_r_q) + ITW'(1)) == it_q) begin
                  ld_r_q <= '0;
                  ld_w_q <= 1'b1;
                end else ld_r_q <= ld_r_q + ITIW'(1);
              end else ld_c_q <= ld_c_q + ITIW'(1);
            end else begin
              if ((ITW'(ld_c_q) + ITW'(1)) == ITW'(k_q)) begin
                ld_c_q <= '0;
                if ((ITW'(ld_r_q) + ITW'(1)) == ITW'(k_q)) begin
                  ld_r_q <= '0;
                  ld_w_q <= 1'b0;
                  kh_q   <= '0;
                  kw_q   <= '0;
                  st_q   <= ST_KPOS;
                end else ld_r_q <= ld_r_q + ITIW'(1);
              end else ld_c_q <= ld_c_q + ITIW'(1);
            end
          end
        end
        ST_KPOS: begin
          if (w_cur == '0) begin
            kh_q <= adv_kh;
            kw_q <= adv_kw;
            ic_q <= adv_ic;
            st_q <= adv_st;
          end else begin
            bh_q  <= '0;
            bw_q  <= '0;
            ih_q  <= i0h - orgh_ext;
            iw_q  <= i0w - orgw_ext;
            iw0_q <= i0w - orgw_ext;
            st_q  <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (bw_nxt >= t_ext) begin
            bw_q <= '0;
            iw_q <= iw0_q;
            if (bh_nxt >= t_ext) begin
              kh_q <= adv_kh;
              kw_q <= adv_kw;
              ic_q <= adv_ic;
              st_q <= adv_st;
            end else begin
              bh_q <= bh_nxt;
              ih_q <= ih_q + IXW'(1);
            end
          end else begin
            bw_q <= bw_nxt;
            iw_q <= iw_q + IXW'(1);
          end
        end
        ST_OUT: begin
          if (out_ready_i) begin
            if ((TW'(out_c_q) + TW'(1)) == t_q) begin
              out_c_q <= '0;
              if ((TW'(out_r_q) + TW'(1)) == t_q) st_q <= ST_DONE;
              else out_r_q <= out_r_q + TIW'(1);
            end else out_c_q <= out_c_q + TIW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (st_q == ST_LOAD);
  assign out_valid_o = (st_q == ST_OUT);
  assign done_o      = (st_q == ST_DONE);
endmodule

// File: rtl/deconv_cu_chk.sv
module deconv_cu_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          done_o
);
  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  // R7
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));

  // R8
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o && !in_ready_o);

  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(out_valid_o && out_ready_i));

  // R3
  load_out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
endmodule

bind deconv_cu deconv_cu_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .done_o      (done_o)
);

// File: tb/deconv_cu_bench.sv
`timescale 1ns/1ps
module deconv_cu_bench;
  localparam int FRAC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  stride_i = '0, pad_i = '0, ksize_i = '0, n_ch_i = '0;
  logic [3:0]  tile_i = '0, in_tile_i = '0;
  logic signed [7:0] in_org_h_i = '0, in_org_w_i = '0;
  logic [31:0] bias_i = '0, in_data_i = '0;
  logic        in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic        in_ready_o, out_valid_o, done_o;
  logic [31:0] out_data_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  deconv_cu u_deconv_cu (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stride_i(stride_i),
    .pad_i(pad_i), .ksize_i(ksize_i), .n_ch_i(n_ch_i), .tile_i(tile_i),
    .in_tile_i(in_tile_i), .in_org_h_i(in_org_h_i), .in_org_w_i(in_org_w_i),
    .bias_i(bias_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .done_o(done_o)
  );

  int checks = 0, errors = 0;
  int unsigned seed = 32'h1234_5678;
  int unsigned lf = 32'hACE1;
  logic [31:0] xin [4][8][8];
  logic [31:0] win [4][4][4];
  logic [31:0] ey [8][8];
  int exp_t = 1, col_idx = 0;
  bit rdy_rand = 1'b0;
  int cyc = 0;

  function automatic int unsigned rnd();
    seed = seed * 1103515245 + 12345;
    return seed >> 8;
  endfunction

  // R9 product rule
  function automatic logic [31:0] mac(logic [31:0] w, logic [31:0] x);
    logic signed [63:0] p;
    p = $signed({{32{w[31]}}, w}) * $signed({{32{x[31]}}, x});
    p = p >>> FRAC;
    return p[31:0];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output collector: R2 R6 R7 order and values
  always @(negedge clk_i) begin
    lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'hB400 : 32'h0);
    out_ready_i = rdy_rand ? (lf[0] | lf[3]) : 1'b1;
    if (out_valid_o && out_ready_i) begin
      chk(out_data_o == ey[col_idx / exp_t][col_idx % exp_t], "R2 R6 R7 pixel",
          out_data_o, ey[col_idx / exp_t][col_idx % exp_t]);
      col_idx++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(logic [31:0] v);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = v;
    @(posedge clk_i);
  endtask

  task automatic run_case(int s, int k, int p, int t, int it, int orh, int orw,
                          int nch, logic [31:0] bias);
    int cnt, nz, nb;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) ey[r][c] = bias;
    for (int c = 0; c < nch; c++)
      for (int kh = 0; kh < k; kh++) for (int kw = 0; kw < k; kw++)
        for (int li = 0; li < it; li++) for (int lj = 0; lj < it; lj++) begin
          int oh, ow;
          oh = (orh + li) * s + kh - p;
          ow = (orw + lj) * s + kw - p;
          if (oh >= 0 && oh < t && ow >= 0 && ow < t)
            ey[oh][ow] = ey[oh][ow] + mac(win[c][kh][kw], xin[c][li][lj]);
        end
    exp_t = t;
    col_idx = 0;
    @(negedge clk_i);
    stride_i = 3'(s); pad_i = 3'(p); ksize_i = 3'(k); n_ch_i = 3'(nch);
    tile_i = 4'(t); in_tile_i = 4'(it); in_org_h_i = 8'(orh); in_org_w_i = 8'(orw);
    bias_i = bias; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R8 done low after start", 32'(done_o), 0);
    cnt = 0;
    while (!in_ready_o) begin @(posedge clk_i); cnt++; @(negedge clk_i); end
    chk(cnt == k, "R10 setup cycles", cnt, k);
    nb = ((t + s - 1) / s) * ((t + s - 1) / s);
    for (int c = 0; c < nch; c++) begin
      nz = 0;
      for (int r = 0; r < it; r++) for (int cc = 0; cc < it; cc++) drive(xin[c][r][cc]);
      for (int kh = 0; kh < k; kh++) for (int kw = 0; kw < k; kw++) begin
        drive(win[c][kh][kw]);
        if (win[c][kh][kw] != 0) nz++;
      end
      @(negedge clk_i);
      in_valid_i = 1'b0;
      cnt = 0;
      while (!(in_ready_o || out_valid_o)) begin @(posedge clk_i); cnt++; @(negedge clk_i); end
      chk(cnt == k * k + nz * nb, nz == 0 ? "R4 zero-skip cycles" : "R5 channel cycles",
          cnt, k * k + nz * nb);
    end
    while (col_idx < t * t) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o && !out_valid_o && !in_ready_o, "R8 done after last beat",
        {out_valid_o, in_ready_o, done_o}, 3'b001);
  endtask

  task automatic fill(int nch, int k, int zero_pct);
    for (int c = 0; c < nch; c++) begin
      for (int r = 0; r < 8; r++) for (int cc = 0; cc < 8; cc++)
        xin[c][r][cc] = 32'(int'(rnd() % 4001) - 2000);
      for (int kh = 0; kh < k; kh++) for (int kw = 0; kw < k; kw++)
        win[c][kh][kw] = (int'(rnd() % 100) < zero_pct) ? 32'h0 : 32'(int'(rnd() % 4001) - 2000);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o && !done_o, "R8 reset state",
        {out_valid_o, in_ready_o, done_o}, 0);

    // R1: all-zero weights give bias everywhere; R4 timing
    fill(2, 3, 100);
    run_case(2, 3, 1, 6, 8, 0, 0, 2, 32'hDEAD_0123);

    // R9: wrap in product and sum
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 8; r++) for (int cc = 0; cc < 8; cc++) xin[c][r][cc] = 32'h7FFF_FF00 - 32'(r * 8 + cc);
      win[c][0][0] = 32'h4000_0000 + 32'(c);
    end
    run_case(1, 1, 0, 4, 4, 0, 0, 2, 32'h7FFF_0000);

    // R2 R3 R5 R6: sweep over stride, kernel, padding
    begin
      int cfg = 0;
      int t_l [4] = '{8, 5, 3, 7};
      int it_l[3] = '{8, 5, 6};
      int o_l [4] = '{0, -1, 1, -2};
      for (int s = 1; s <= 3; s++)
        for (int k = 1; k <= 4; k++)
          for (int p = 0; p < k; p++) begin
            int nch;
            nch = 1 + (cfg % 3);
            rdy_rand = (cfg % 2) == 1;
            fill(nch, k, 30);
            run_case(s, k, p, t_l[cfg % 4], it_l[cfg % 3], o_l[cfg % 4], o_l[(cfg + 1) % 4],
                     nch, 32'(cfg * 17 - 100));
            cfg++;
          end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule